// File: doc/BRIEF.md
# Single-Pin Return-to-One Bus Frame Receiver

This block is the receiving end of a single-wire, open-drain serial bus on which every bit is a return-to-one frame. Each frame opens with a falling edge and carries its value in the line level a fixed time after that edge. The line then goes back high before the next frame. The host opens every transaction with a break, which is a low pulse much longer than any bit frame. The host then releases the line for a recovery interval and sends a command byte least significant bit first. The command byte holds a 7-bit register address and a direction flag in its top bit.

The receiver passes the raw line through a two-stage synchronizer. It measures low and high times in clock cycles and tells a break from a data bit by low duration alone. Each bit is recovered by sampling at a fixed delay after its falling edge. Every decoded command is reported with a one-cycle strobe. For a write, a further 8 or 16 bits are assembled, and a one-cycle write strobe presents the address and data to a register file. The payload width is chosen by an input. Timing faults raise a one-cycle framing-error pulse. After a fault the receiver ignores the line until the next break. The pull-down output is part of the pin interface and is held released, because this block sends no responses.

Top module: `rtone_rx`

## Requirements
- R1: A low period of at least BREAK_CYC cycles on the synchronized line is a break. It discards any partly received command, and the receiver then waits for recovery. A low of BREAK_CYC-1 cycles from idle is not a break, and the command after it is ignored.
- R2: After a break, the line must stay high for at least RECOV_CYC cycles before a falling edge starts the first frame. An earlier falling edge pulses frame_err_o, and the command that follows is ignored.
- R3: Bits arrive least significant bit first. The first 8 bits are the command: bits 0 to 6 are the address (cmd_addr_o), and bit 7 is the direction flag, where 1 means write and 0 means read. cmd_rd_o is the inverse of bit 7.
- R4: Each bit takes the synchronized line level SAMPLE_CYC cycles after its falling edge is detected, where low means 0 and high means 1. With the default SAMPLE_CYC of 8, a bit held low for 8 cycles reads as 1 and one held low for 9 cycles reads as 0.
- R5: A read command gives one cmd_valid_o pulse with cmd_rd_o high. No payload is taken and wr_valid_o stays low.
- R6: A write command gives cmd_valid_o with cmd_rd_o low. The payload width is taken from wide_i at command completion: 16 bits when it is 1, otherwise 8 bits zero-extended. A one-cycle wr_valid_o pulse then presents wr_addr_o equal to the command address and wr_data_o equal to the payload.
- R7: A low period longer than STOP_MAX_CYC cycles inside a transaction, but shorter than a break, pulses frame_err_o. No strobe is produced, and the line is ignored until the next break.
- R8: A frame whose falling-edge-to-falling-edge period is shorter than CYCLE_MIN_CYC cycles pulses frame_err_o, and the transaction is dropped. A period of exactly CYCLE_MIN_CYC is accepted.
- R9: cmd_valid_o and wr_valid_o go high exactly SAMPLE_CYC+3 clock cycles after the line falls for the final bit of the command or of the payload, and each stays high for one cycle.
- R10: drive_low_o is always 0.
- R11: After reset, cmd_valid_o, wr_valid_o and frame_err_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw bus line level, asynchronous to clk |
| wide_i | input | 1 | Payload width select: 1 for PAY_W bits, 0 for NARROW_W bits |
| drive_low_o | output | 1 | Pull-down enable for the open-drain pin, held 0 |
| cmd_valid_o | output | 1 | One-cycle strobe when a command byte is complete |
| cmd_rd_o | output | 1 | Command is a read (valid with cmd_valid_o) |
| cmd_addr_o | output | 7 | Register address of the command |
| wr_valid_o | output | 1 | One-cycle strobe when a write payload is complete |
| wr_addr_o | output | 7 | Register address for the write |
| wr_data_o | output | PAY_W | Write payload, zero-extended when narrow |
| frame_err_o | output | 1 | One-cycle pulse on a framing fault |

## Verification
Each strobe is due SAMPLE_CYC+3 cycles after the line falls for the final bit. Two of those cycles are the synchronizer, one is edge detection and the rest is the sample delay. The bench timestamps every falling edge it drives and every strobe it sees at falling clock edges, and compares the difference against that constant. Framing errors and strobe counts are collected over a whole transaction and checked after the line has been idle for several cycles. The sample point, the recovery interval, the break length and the minimum period are each driven one cycle on either side of their limits.

// File: rtl/rtone_pkg.sv
package rtone_pkg;
   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_BRK   = 3'd1,
      RX_RECOV = 3'd2,
      RX_READY = 3'd3,
      RX_FRAME = 3'd4
   } rx_state_e;

   localparam int unsigned CMD_W  = 8;
   localparam int unsigned ADDR_W = CMD_W - 1;
endpackage

// File: rtl/rtone_sync.sv
module rtone_sync #(
   parameter int unsigned STAGES = 2,
   parameter logic        INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("rtone_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= INIT;
            else        chain_q <= d_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{INIT}};
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rtone_satcnt.sv
module rtone_satcnt #(
   parameter  int unsigned MAXV = 8,
   localparam int unsigned W    = $clog2(MAXV + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   generate
      if (MAXV < 1) begin : g_bad_max
         $error("rtone_satcnt: MAXV must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_o <= '0;
      else if (clear_i)
         cnt_o <= '0;
      else if (inc_i && (cnt_o != W'(MAXV)))
         cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/rtone_deser.sv
module rtone_deser #(
   parameter  int unsigned W  = 8,
   localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          wr_i,
   input  logic [IW-1:0] idx_i,
   input  logic          bit_i,
   output logic [W-1:0]  word_nx_o
);
   logic [W-1:0] word_q;

   always_comb begin
      word_nx_o = word_q;
      if (wr_i) word_nx_o[idx_i] = bit_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (clr_i) word_q <= '0;
      else            word_q <= word_nx_o;
   end
endmodule

// File: rtl/rtone_rx.sv
module rtone_rx
   import rtone_pkg::*;
#(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned BREAK_CYC     = 40,
   parameter int unsigned RECOV_CYC     = 10,
   parameter int unsigned SAMPLE_CYC    = 8,
   parameter int unsigned STOP_MAX_CYC  = 16,
   parameter int unsigned CYCLE_MIN_CYC = 24,
   parameter int unsigned PAY_W         = 16,
   parameter int unsigned NARROW_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_i,
   input  logic             wide_i,
   output logic             drive_low_o,
   output logic             cmd_valid_o,
   output logic             cmd_rd_o,
   output logic [6:0]       cmd_addr_o,
   output logic             wr_valid_o,
   output logic [6:0]       wr_addr_o,
   output logic [PAY_W-1:0] wr_data_o,
   output logic             frame_err_o
);
   localparam int unsigned LW  = $clog2(BREAK_CYC + 1);
   localparam int unsigned HW  = $clog2(RECOV_CYC + 1);
   localparam int unsigned FW  = $clog2(CYCLE_MIN_CYC + 1);
   localparam int unsigned BW  = $clog2(PAY_W);
   localparam int unsigned CIW = $clog2(CMD_W);

   generate
      if (SAMPLE_CYC < 2 || SAMPLE_CYC >= STOP_MAX_CYC) begin : g_bad_sample
         $error("rtone_rx: SAMPLE_CYC must lie in 2..STOP_MAX_CYC-1");
      end
      if (STOP_MAX_CYC >= BREAK_CYC) begin : g_bad_stop
         $error("rtone_rx: STOP_MAX_CYC must be below BREAK_CYC");
      end
      if (CYCLE_MIN_CYC <= STOP_MAX_CYC) begin : g_bad_cycle
         $error("rtone_rx: CYCLE_MIN_CYC must exceed STOP_MAX_CYC");
      end
      if (RECOV_CYC < 2) begin : g_bad_recov
         $error("rtone_rx: RECOV_CYC must be at least 2");
      end
      if (PAY_W < CMD_W || NARROW_W >= PAY_W || NARROW_W < 1) begin : g_bad_width
         $error("rtone_rx: need CMD_W <= PAY_W and 1 <= NARROW_W < PAY_W");
      end
   endgenerate

   // line conditioning and edge detection
   logic ln, ln_q, fall;

   rtone_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(ln)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ln_q <= 1'b1;
      else        ln_q <= ln;
   end
   assign fall = ln_q & ~ln;

   // duration counters: consecutive low, consecutive high, since last fall
   logic [LW-1:0] lo_cnt;
   logic [HW-1:0] hi_cnt;
   logic [FW-1:0] fr_cnt;

   rtone_satcnt #(.MAXV(BREAK_CYC)) u_lo_cnt (
      .clk(clk), .rst_n(rst_n), .clear_i(ln), .inc_i(~ln), .cnt_o(lo_cnt)
   );
   rtone_satcnt #(.MAXV(RECOV_CYC)) u_hi_cnt (
      .clk(clk), .rst_n(rst_n), .clear_i(~ln), .inc_i(ln), .cnt_o(hi_cnt)
   );
   rtone_satcnt #(.MAXV(CYCLE_MIN_CYC)) u_fr_cnt (
      .clk(clk), .rst_n(rst_n), .clear_i(fall), .inc_i(1'b1), .cnt_o(fr_cnt)
   );

   rx_state_e        state;
   logic [BW-1:0]    bit_idx;
   logic             in_pay;
   logic             wide_q;

   logic brk_hit, stop_late, short_cyc, rec_done, smp_now;
   assign brk_hit   = ~ln && (lo_cnt == LW'(BREAK_CYC - 1));
   assign stop_late = ~ln && (lo_cnt == LW'(STOP_MAX_CYC));
   assign short_cyc = fall && (fr_cnt < FW'(CYCLE_MIN_CYC - 1));
   assign rec_done  = ln && (hi_cnt == HW'(RECOV_CYC - 1));
   assign smp_now   = (state == RX_FRAME) && !fall && (fr_cnt == FW'(SAMPLE_CYC - 1));

   logic cmd_last, pay_last;
   assign cmd_last = (bit_idx == BW'(CMD_W - 1));
   assign pay_last = (bit_idx == (wide_q ? BW'(PAY_W - 1) : BW'(NARROW_W - 1)));

   // bit assembly
   logic             cmd_wr, cmd_clr, pay_wr, pay_clr;
   logic [CMD_W-1:0] cmd_nx;
   logic [PAY_W-1:0] pay_nx;

   assign cmd_clr = (state == RX_READY) && fall;
   assign cmd_wr  = smp_now && !in_pay;
   assign pay_wr  = smp_now && in_pay;
   assign pay_clr = cmd_wr && cmd_last;

   rtone_deser #(.W(CMD_W)) u_cmd_sr (
      .clk(clk), .rst_n(rst_n), .clr_i(cmd_clr), .wr_i(cmd_wr),
      .idx_i(bit_idx[CIW-1:0]), .bit_i(ln), .word_nx_o(cmd_nx)
   );
   rtone_deser #(.W(PAY_W)) u_pay_sr (
      .clk(clk), .rst_n(rst_n), .clr_i(pay_clr), .wr_i(pay_wr),
      .idx_i(bit_idx), .bit_i(ln), .word_nx_o(pay_nx)
   );

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= RX_IDLE;
         bit_idx     <= '0;
         in_pay      <= 1'b0;
         wide_q      <= 1'b0;
         cmd_valid_o <= 1'b0;
         cmd_rd_o    <= 1'b0;
         cmd_addr_o  <= '0;
         wr_valid_o  <= 1'b0;
         wr_addr_o   <= '0;
         wr_data_o   <= '0;
         frame_err_o <= 1'b0;
      end else begin
         cmd_valid_o <= 1'b0;
         wr_valid_o  <= 1'b0;
         frame_err_o <= 1'b0;
         if (brk_hit) begin
            state <= RX_BRK;
         end else begin
            unique case (state)
               RX_IDLE: ;
               RX_BRK: if (ln) state <= RX_RECOV;
               RX_RECOV: begin
                  if (fall) begin
                     frame_err_o <= 1'b1;
                     state       <= RX_IDLE;
                  end else if (rec_done) begin
                     state <= RX_READY;
                  end
               end
               RX_READY: begin
                  if (fall) begin
                     state   <= RX_FRAME;
                     bit_idx <= '0;
                     in_pay  <= 1'b0;
                  end
               end
               RX_FRAME: begin
                  if (short_cyc || stop_late) begin
                     frame_err_o <= 1'b1;
                     state       <= RX_IDLE;
                  end else if (smp_now) begin
                     if (!in_pay) begin
                        if (cmd_last) begin
                           cmd_valid_o <= 1'b1;
                           cmd_addr_o  <= cmd_nx[ADDR_W-1:0];
                           cmd_rd_o    <= ~cmd_nx[CMD_W-1];
                           if (cmd_nx[CMD_W-1]) begin
                              in_pay  <= 1'b1;
                              bit_idx <= '0;
                              wide_q  <= wide_i;
                           end else begin
                              state <= RX_IDLE;
                           end
                        end else begin
                           bit_idx <= bit_idx + 1'b1;
                        end
                     end else if (pay_last) begin
                        wr_valid_o <= 1'b1;
                        wr_addr_o  <= cmd_addr_o;
                        wr_data_o  <= pay_nx;
                        state      <= RX_IDLE;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                     end
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   assign drive_low_o = 1'b0;
endmodule

// File: rtl/rtone_rx_chk.sv
module rtone_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid_o,
   input logic       cmd_rd_o,
   input logic [6:0] cmd_addr_o,
   input logic       wr_valid_o,
   input logic [6:0] wr_addr_o,
   input logic       frame_err_o
);
   logic       seen_cmd;
   logic       last_rd;
   logic [6:0] last_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_cmd  <= 1'b0;
         last_rd   <= 1'b0;
         last_addr <= '0;
      end else if (cmd_valid_o) begin
         seen_cmd  <= 1'b1;
         last_rd   <= cmd_rd_o;
         last_addr <= cmd_addr_o;
      end
   end

   // R9: command strobe lasts one cycle
   p_cmd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |=> !cmd_valid_o);

   // R6: write strobe lasts one cycle
   p_wr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |=> !wr_valid_o);

   // R5: a write strobe only follows a write command
   p_wr_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> (seen_cmd && !last_rd));

   // R6: write address equals the address of the preceding command
   p_wr_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> (wr_addr_o == last_addr));

   // R7: a framing error never coincides with a strobe
   p_err_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> (!cmd_valid_o && !wr_valid_o));
endmodule

bind rtone_rx rtone_rx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid_o(cmd_valid_o),
   .cmd_rd_o   (cmd_rd_o),
   .cmd_addr_o (cmd_addr_o),
   .wr_valid_o (wr_valid_o),
   .wr_addr_o  (wr_addr_o),
   .frame_err_o(frame_err_o)
);

// File: tb/rtone_rx_tb_top.sv
`timescale 1ns/1ps
module rtone_rx_tb_top;
   localparam int BRK   = 40;
   localparam int REC   = 10;
   localparam int SMP   = 8;
   localparam int STOPM = 16;
   localparam int CYMIN = 24;
   localparam int LAT   = SMP + 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_in = 1'b1;
   logic        wide_in = 1'b0;
   logic        drive_low_o, cmd_valid_o, cmd_rd_o, wr_valid_o, frame_err_o;
   logic [6:0]  cmd_addr_o, wr_addr_o;
   logic [15:0] wr_data_o;

   always #10 clk = ~clk;

   rtone_rx dut_i (
      .clk(clk), .rst_n(rst_n), .line_i(line_in), .wide_i(wide_in),
      .drive_low_o(drive_low_o), .cmd_valid_o(cmd_valid_o), .cmd_rd_o(cmd_rd_o),
      .cmd_addr_o(cmd_addr_o), .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .frame_err_o(frame_err_o)
   );

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;
   int last_fall = 0;
   int m_cmd_n, m_cmd_lat, m_wr_n, m_wr_lat, m_err_n;
   int pull_bad = 0;
   logic [6:0]  m_cmd_addr, m_wr_addr;
   logic        m_cmd_rd;
   logic [15:0] m_wr_data;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (drive_low_o !== 1'b0) pull_bad++;
         if (cmd_valid_o) begin
            m_cmd_n++; m_cmd_addr = cmd_addr_o; m_cmd_rd = cmd_rd_o;
            m_cmd_lat = cyc - last_fall;
         end
         if (wr_valid_o) begin
            m_wr_n++; m_wr_addr = wr_addr_o; m_wr_data = wr_data_o;
            m_wr_lat = cyc - last_fall;
         end
         if (frame_err_o) m_err_n++;
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_payload(input logic [15:0] d, input logic wd);
      return wd ? d : {8'h00, d[7:0]};
   endfunction

   task automatic clear_mon();
      m_cmd_n = 0; m_wr_n = 0; m_err_n = 0; m_cmd_lat = -1; m_wr_lat = -1;
      m_cmd_addr = '0; m_cmd_rd = 1'b0; m_wr_addr = '0; m_wr_data = '0;
   endtask

   task automatic hold(input logic v, input int n);
      line_in = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_break(input int lo, input int rec);
      hold(1'b0, lo);
      hold(1'b1, rec);
   endtask

   task automatic send_bit(input int lo, input int per);
      last_fall = cyc;
      hold(1'b0, lo);
      hold(1'b1, per - lo);
   endtask

   task automatic send_rand_bit(input logic b);
      int lo, per;
      lo  = b ? 1 + int'($urandom % 6) : SMP + 2 + int'($urandom % 6);
      per = CYMIN + int'($urandom % 9);
      send_bit(lo, per);
   endtask

   task automatic send_word(input logic [15:0] v, input int n);
      for (int i = 0; i < n; i++) send_rand_bit(v[i]);
   endtask

   task automatic xact(input logic [6:0] a, input logic wr, input logic [15:0] d,
                       input logic wd);
      logic [15:0] exp;
      wide_in = wd;
      clear_mon();
      send_break(BRK + 4, REC + int'($urandom % 5));
      send_word({8'h00, wr, a}, 8);
      if (wr) send_word(d, wd ? 16 : 8);
      hold(1'b1, 6);
      exp = exp_payload(d, wd);
      check(m_cmd_n == 1, wr ? "R6" : "R5", "command strobe count", m_cmd_n, 1);
      check(m_cmd_addr == a, "R3", "command address", m_cmd_addr, a);
      check(m_cmd_rd == !wr, "R3", "read flag", m_cmd_rd, !wr);
      check(m_cmd_lat == LAT, "R9", "command strobe latency", m_cmd_lat, LAT);
      check(m_wr_n == (wr ? 1 : 0), wr ? "R6" : "R5", "write strobe count", m_wr_n, wr ? 1 : 0);
      if (wr) begin
         check(m_wr_data == exp, "R6", "write data", m_wr_data, exp);
         check(m_wr_addr == a, "R6", "write address", m_wr_addr, a);
         check(m_wr_lat == LAT, "R9", "write strobe latency", m_wr_lat, LAT);
      end
      check(m_err_n == 0, "R7", "no framing error on clean traffic", m_err_n, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      clear_mon();
      repeat (3) @(negedge clk);
      check(cmd_valid_o == 1'b0, "R11", "cmd_valid after reset", cmd_valid_o, 0);
      check(wr_valid_o == 1'b0, "R11", "wr_valid after reset", wr_valid_o, 0);
      check(frame_err_o == 1'b0, "R11", "frame_err after reset", frame_err_o, 0);
      check(drive_low_o == 1'b0, "R10", "pull-down after reset", drive_low_o, 0);
      rst_n = 1'b1;
      hold(1'b1, 10);

      // directed basic traffic
      xact(7'h5A, 1'b0, 16'h0000, 1'b0);
      xact(7'h01, 1'b1, 16'hBEEF, 1'b1);
      xact(7'h7F, 1'b1, 16'hC3A5, 1'b0);

      // R4: sample point boundary, low for SMP reads 1, low for SMP+1 reads 0
      wide_in = 1'b0; clear_mon();
      send_break(BRK + 4, REC + 2);
      send_word({8'h00, 1'b1, 7'h2A}, 8);
      for (int i = 0; i < 8; i++) send_bit(SMP, 28);
      hold(1'b1, 6);
      check(m_wr_n == 1 && m_wr_data == 16'h00FF, "R4", "low SMP cycles samples 1",
            m_wr_data, 16'h00FF);
      clear_mon();
      send_break(BRK + 4, REC + 2);
      send_word({8'h00, 1'b1, 7'h2A}, 8);
      for (int i = 0; i < 8; i++) send_bit(SMP + 1, 28);
      hold(1'b1, 6);
      check(m_wr_n == 1 && m_wr_data == 16'h0000, "R4", "low SMP+1 cycles samples 0",
            m_wr_data, 16'h0000);

      // R2: recovery one cycle short is rejected, exact recovery accepted
      clear_mon();
      send_break(BRK + 4, REC - 1);
      send_word({8'h00, 1'b0, 7'h11}, 8);
      hold(1'b1, 6);
      check(m_cmd_n == 0, "R2", "short recovery ignores command", m_cmd_n, 0);
      check(m_err_n == 1, "R2", "short recovery flags error", m_err_n, 1);
      clear_mon();
      send_break(BRK + 4, REC);
      send_word({8'h00, 1'b0, 7'h11}, 8);
      hold(1'b1, 6);
      check(m_cmd_n == 1 && m_cmd_addr == 7'h11, "R2", "exact recovery accepted",
            m_cmd_n, 1);

      // R1: low one cycle short of a break is not a break
      clear_mon();
      send_break(BRK - 1, REC + 4);
      send_word({8'h00, 1'b0, 7'h33}, 8);
      hold(1'b1, 6);
      check(m_cmd_n == 0, "R1", "sub-break low does not start command", m_cmd_n, 0);
      // R1: break in mid-command discards the partial command
      clear_mon();
      send_break(BRK, REC + 3);
      send_word(16'h000F, 4);
      send_break(BRK + 2, REC + 3);
      send_word({8'h00, 1'b0, 7'h4C}, 8);
      hold(1'b1, 6);
      check(m_cmd_n == 1, "R1", "one command after restart", m_cmd_n, 1);
      check(m_cmd_addr == 7'h4C, "R1", "address from restarted command", m_cmd_addr, 7'h4C);

      // R7: over-long low inside a frame
      clear_mon();
      send_break(BRK + 4, REC + 4);
      send_word(16'h0005, 3);
      send_bit(STOPM + 8, STOPM + 18);
      send_word({8'h00, 1'b0, 7'h22}, 8);
      hold(1'b1, 6);
      check(m_err_n == 1, "R7", "long low flags error", m_err_n, 1);
      check(m_cmd_n == 0, "R7", "line ignored until next break", m_cmd_n, 0);

      // R8: period one cycle short of the minimum
      clear_mon();
      send_break(BRK + 4, REC + 4);
      send_bit(3, 28);
      send_bit(3, CYMIN - 1);
      send_word({8'h00, 1'b0, 7'h66}, 8);
      hold(1'b1, 6);
      check(m_err_n == 1, "R8", "short period flags error", m_err_n, 1);
      check(m_cmd_n == 0, "R8", "short period drops command", m_cmd_n, 0);
      clear_mon();
      send_break(BRK + 4, REC + 4);
      for (int i = 0; i < 8; i++) send_bit((i % 2 == 0) ? 3 : SMP + 4, CYMIN);
      hold(1'b1, 6);
      check(m_err_n == 0 && m_cmd_n == 1, "R8", "minimum period accepted", m_cmd_n, 1);
      check(m_cmd_addr == 7'h55 && m_cmd_rd == 1'b1, "R3", "alternating bits LSB first",
            m_cmd_addr, 7'h55);

      // constrained random traffic
      for (int t = 0; t < 24; t++) begin
         xact(7'($urandom), 1'($urandom), 16'($urandom), 1'($urandom));
      end

      check(pull_bad == 0, "R10", "pull-down stays released", pull_bad, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule